// File: doc/BRIEF.md
# DQS Write Leveling Sequencer

This block drives the search that lines up each byte lane's write strobe with the memory clock. The memory must already be in leveling mode, and the block only issues requests for entering and leaving it. The block takes the lanes one at a time. For each lane it selects the lane and resets the lane's DQ and DQS write delays. It then repeats one step: fire a leveling strobe, wait a fixed settling time, and look at the feedback byte the memory returns. Between samples it moves the DQ and DQS delays forward together by one tap.

A lane normally starts in the region where the feedback reads zero. The block steps that lane until the feedback turns non-zero and records the tap count. Some lanes start with the feedback already non-zero. The block treats such a lane as having one to two bit times of skew and marks it. It first steps the lane forward until the feedback reads zero, and only then looks for the rising edge. Neither search can pass a fixed tap limit. When every lane is done, the block reports one pass/fail flag for the whole run.

Top module: `wrlvl_seq`

## Requirements
- R1: A `start` pulse while idle produces a one-cycle `lvl_mode_on` pulse. The first `dly_rst` pulse comes exactly SETTLE+1 cycles after the `lvl_mode_on` cycle.
- R2: Lanes are processed in ascending order. During a lane's work `lane_sel` is one-hot with bit i set for lane i, and it is zero when no lane is in work. Each lane starts with exactly one `dly_rst` pulse, and its tap count starts at 0.
- R3: The feedback byte is sampled exactly SAMPLE_WAIT+1 cycles after each `lvl_strobe` cycle. Its value in any other cycle has no effect on the results.
- R4: A lane whose first sample is non-zero (any bit set) gets `hi_skew_o[i]`=1. It is stepped until a sample reads zero.
- R5: A lane in the zero region is stepped until a sample is non-zero. Lane i's final tap count is stored in `taps_o[i*TAP_W +: TAP_W]`, and the count equals the number of increment steps applied.
- R6: Every step pulses `dq_inc` and `dqs_inc` together for one cycle. No step coincides with `lvl_strobe` or `dly_rst`.
- R7: If the next step would bring the count to TAP_LIMIT, the lane ends with the count stored as TAP_LIMIT and that final step is not issued. This holds in either search phase.
- R8: After the last lane, `lvl_mode_off` pulses for one cycle and `done` pulses in the next cycle. `ok` is 1 only if no lane stored TAP_LIMIT.
- R9: After reset, `busy`, `done`, `ok`, `lane_sel`, all pulse outputs, `taps_o` and `hi_skew_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a leveling run (honoured when idle) |
| fb_byte | input | FB_W | Feedback byte sampled from the memory |
| lvl_mode_on | output | 1 | Request to enter leveling mode |
| lvl_mode_off | output | 1 | Request to leave leveling mode |
| lane_sel | output | LANES | One-hot lane under adjustment |
| dly_rst | output | 1 | Reset the selected lane's DQ and DQS delays |
| dq_inc | output | 1 | Step the selected lane's DQ write delay |
| dqs_inc | output | 1 | Step the selected lane's DQS write delay |
| lvl_strobe | output | 1 | Fire one leveling strobe |
| taps_o | output | LANES*TAP_W | Per-lane final tap count |
| hi_skew_o | output | LANES | Per-lane high-skew flag |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | No lane reached the tap limit |

## Verification
The bench's memory model puts the correct feedback on the bus only in the one cycle the block should sample. In every other cycle it drives the opposite value, so a sequencer that samples one cycle early or late ends up with wrong tap counts. Some lanes start high-skew, with a zero window beginning at tap 1. A design that skipped the first phase would stop at tap 0, and one that dropped the flag would report no skew. Some lanes put either edge at TAP_LIMIT-1, TAP_LIMIT or beyond, which catches off-by-one errors in the limit, such as issuing a step past it or storing one less than the limit. A lane whose rising edge sits at tap 1 catches counters that go wrong on the very first step.

// File: rtl/wrlvl_seq.sv
module wrlvl_seq #(
  parameter int LANES       = 4,
  parameter int TAP_W       = 6,
  parameter int TAP_LIMIT   = 32,
  parameter int SETTLE      = 100,
  parameter int SAMPLE_WAIT = 10,
  parameter int FB_W        = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [FB_W-1:0]        fb_byte,
  output logic                   lvl_mode_on,
  output logic                   lvl_mode_off,
  output logic [LANES-1:0]       lane_sel,
  output logic                   dly_rst,
  output logic                   dq_inc,
  output logic                   dqs_inc,
  output logic                   lvl_strobe,
  output logic [LANES*TAP_W-1:0] taps_o,
  output logic [LANES-1:0]       hi_skew_o,
  output logic                   busy,
  output logic                   done,
  output logic                   ok
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int CNT_W  = $clog2(SETTLE + SAMPLE_WAIT + 1);
  localparam logic [TAP_W-1:0]  LIM     = TAP_W'(TAP_LIMIT);
  localparam logic [TAP_W-1:0]  LIM_M1  = TAP_W'(TAP_LIMIT - 1);
  localparam logic [LANE_W-1:0] LAST    = LANE_W'(LANES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ON, S_SETTLE, S_INIT, S_STRB, S_WAIT, S_SAMP, S_INC, S_OFF, S_DONE
  } st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [LANE_W-1:0] lane;
  logic [TAP_W-1:0]  tap;
  logic              phase;
  logic              lim_hit;
  logic              fb_nz;

  assign fb_nz        = |fb_byte;
  assign lvl_mode_on  = (st == S_ON);
  assign lvl_mode_off = (st == S_OFF);
  assign dly_rst      = (st == S_INIT);
  assign lvl_strobe   = (st == S_STRB);
  assign dq_inc       = (st == S_INC);
  assign dqs_inc      = (st == S_INC);
  assign busy         = (st != S_IDLE);
  assign done         = (st == S_DONE);
  assign lane_sel     = (st inside {S_INIT, S_STRB, S_WAIT, S_SAMP, S_INC})
                        ? (LANES'(1) << lane) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      lane      <= '0;
      tap       <= '0;
      phase     <= 1'b0;
      lim_hit   <= 1'b0;
      taps_o    <= '0;
      hi_skew_o <= '0;
      ok        <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st        <= S_ON;
          taps_o    <= '0;
          hi_skew_o <= '0;
          ok        <= 1'b0;
          lim_hit   <= 1'b0;
        end
        S_ON: begin
          st   <= S_SETTLE;
          cnt  <= '0;
          lane <= '0;
        end
        S_SETTLE:
          if (cnt == CNT_W'(SETTLE - 1)) st <= S_INIT;
          else cnt <= cnt + 1'b1;
        S_INIT: begin
          tap   <= '0;
          phase <= 1'b0;
          st    <= S_STRB;
        end
        S_STRB: begin
          cnt <= '0;
          st  <= S_WAIT;
        end
        S_WAIT:
          if (cnt == CNT_W'(SAMPLE_WAIT - 1)) st <= S_SAMP;
          else cnt <= cnt + 1'b1;
        S_SAMP: begin
          if (tap == '0 && fb_nz) hi_skew_o[lane] <= 1'b1;
          if (!fb_nz) phase <= 1'b1;
          if ((phase && fb_nz) || tap == LIM_M1) begin
            taps_o[lane*TAP_W +: TAP_W] <= (phase && fb_nz) ? tap : LIM;
            if (!(phase && fb_nz)) lim_hit <= 1'b1;
            if (lane == LAST) st <= S_OFF;
            else begin
              lane <= lane + 1'b1;
              st   <= S_INIT;
            end
          end else begin
            tap <= tap + 1'b1;
            st  <= S_INC;
          end
        end
        S_INC:  st <= S_STRB;
        S_OFF: begin
          ok <= !lim_hit;
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module wrlvl_seq_chk #(
  parameter int LANES       = 4,
  parameter int SAMPLE_WAIT = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lvl_mode_on,
  input logic             lvl_mode_off,
  input logic [LANES-1:0] lane_sel,
  input logic             dly_rst,
  input logic             dq_inc,
  input logic             dqs_inc,
  input logic             lvl_strobe,
  input logic             done
);
  localparam int GAP_W = $clog2(SAMPLE_WAIT + 4);
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) gap <= '0;
    else if (lvl_strobe) gap <= GAP_W'(1);
    else if (gap != '0 && gap != GAP_W'(SAMPLE_WAIT + 3)) gap <= gap + 1'b1;
  end

  p_mode_on_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_mode_on |=> !lvl_mode_on);
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_sel));
  p_sel_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_rst || dq_inc || lvl_strobe) |-> $countones(lane_sel) == 1);
  p_sample_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_inc |-> gap == GAP_W'(SAMPLE_WAIT + 2));
  p_inc_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_inc == dqs_inc);
  p_step_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_inc |-> !lvl_strobe && !dly_rst);
  p_done_after_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(lvl_mode_off));
endmodule

bind wrlvl_seq wrlvl_seq_chk #(.LANES(LANES), .SAMPLE_WAIT(SAMPLE_WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .lvl_mode_on(lvl_mode_on), .lvl_mode_off(lvl_mode_off),
  .lane_sel(lane_sel), .dly_rst(dly_rst), .dq_inc(dq_inc), .dqs_inc(dqs_inc),
  .lvl_strobe(lvl_strobe), .done(done));

// File: tb/wrlvl_seq_tb_top.sv
module wrlvl_seq_tb_top;
  localparam int LANES = 4, TAP_W = 6, LIMIT = 32, SETTLE = 100, WAIT = 10, FB_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [FB_W-1:0] fb_byte = '0;
  logic lvl_mode_on, lvl_mode_off, dly_rst, dq_inc, dqs_inc, lvl_strobe, busy, done, ok;
  logic [LANES-1:0] lane_sel, hi_skew_o;
  logic [LANES*TAP_W-1:0] taps_o;

  always #10 clk = ~clk;

  wrlvl_seq #(.LANES(LANES), .TAP_W(TAP_W), .TAP_LIMIT(LIMIT), .SETTLE(SETTLE),
              .SAMPLE_WAIT(WAIT), .FB_W(FB_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fb_byte(fb_byte),
    .lvl_mode_on(lvl_mode_on), .lvl_mode_off(lvl_mode_off), .lane_sel(lane_sel),
    .dly_rst(dly_rst), .dq_inc(dq_inc), .dqs_inc(dqs_inc), .lvl_strobe(lvl_strobe),
    .taps_o(taps_o), .hi_skew_o(hi_skew_o), .busy(busy), .done(done), .ok(ok));

  int n_chk = 0, n_bad = 0;
  int hs[LANES], es[LANES];

  task automatic chk(input bit good, input string req, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_tap(input int e);
    return (e >= LIMIT) ? LIMIT : e;
  endfunction

  function automatic bit fb_true(input int ln, input int pos);
    return (pos < hs[ln]) || (pos >= es[ln]);
  endfunction

  function automatic int sel_idx(input logic [LANES-1:0] s);
    for (int i = 0; i < LANES; i++) if (s == LANES'(1) << i) return i;
    return -1;
  endfunction

  task automatic run_case();
    int cyc = 0, on_cyc = -1, first_rst = -1, next_lane = 0, cur = 0;
    int pos = 0, since = 1000, steps = 0;
    bit off_seen = 0, fin = 0, exp_ok = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!fin) begin
      if (lvl_mode_on) on_cyc = cyc;
      if (dly_rst) begin
        if (first_rst < 0) begin
          first_rst = cyc;
          chk(cyc - on_cyc == SETTLE + 1, "R1 settle gap", cyc - on_cyc, SETTLE + 1);
        end
        chk(sel_idx(lane_sel) == next_lane, "R2 lane order", sel_idx(lane_sel), next_lane);
        if (next_lane > 0) chk(steps == exp_tap(es[next_lane-1]) - ((es[next_lane-1] >= LIMIT) ? 1 : 0),
                               "R5 steps applied", steps, exp_tap(es[next_lane-1]));
        cur = next_lane; next_lane++; pos = 0; steps = 0;
      end
      if (dq_inc || dqs_inc) begin
        chk(dq_inc && dqs_inc && !lvl_strobe, "R6 paired step", {dq_inc, dqs_inc}, 3);
        pos++; steps++;
      end
      since = lvl_strobe ? 0 : since + 1;
      if (lvl_mode_off) off_seen = 1;
      if (done) begin
        chk(off_seen, "R8 off before done", off_seen, 1);
        for (int i = 0; i < LANES; i++) begin
          chk(int'(taps_o[i*TAP_W +: TAP_W]) == exp_tap(es[i]), "R5/R7 tap count",
              int'(taps_o[i*TAP_W +: TAP_W]), exp_tap(es[i]));
          chk(hi_skew_o[i] == (hs[i] > 0), "R4 high-skew flag", hi_skew_o[i], hs[i] > 0);
          if (es[i] >= LIMIT) exp_ok = 0;
        end
        chk(ok == exp_ok, "R8 ok flag", ok, exp_ok);
        chk(next_lane == LANES, "R2 lane count", next_lane, LANES);
        fin = 1;
      end
      if (since == WAIT + 1)
        fb_byte = fb_true(cur, pos) ? FB_W'(($urandom % 255) + 1) : '0;
      else
        fb_byte = fb_true(cur, pos) ? '0 : FB_W'(($urandom % 255) + 1);
      cyc++;
      if (cyc > 20000) begin
        chk(0, "R8 watchdog", cyc, 20000);
        fin = 1;
      end
      @(negedge clk);
    end
    chk(!busy && !done && lane_sel == '0, "R2 idle after run", busy, 0);
  endtask

  task automatic set_lane(input int i, input int h, input int e);
    hs[i] = h; es[i] = e;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ok && lane_sel == '0 && taps_o == '0 && hi_skew_o == '0 &&
        !lvl_mode_on && !dq_inc && !lvl_strobe && !dly_rst, "R9 reset state", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && taps_o == '0, "R9 idle after reset", busy, 0);

    set_lane(0, 0, 5);  set_lane(1, 0, 1);  set_lane(2, 0, 17); set_lane(3, 0, 9);
    run_case();   // R5 plain lanes, rising edge at tap 1
    set_lane(0, 1, 4);  set_lane(1, 3, 10); set_lane(2, 0, 2);  set_lane(3, 6, 7);
    run_case();   // R4 high-skew lanes
    set_lane(0, 0, LIMIT - 1); set_lane(1, 0, LIMIT); set_lane(2, 0, 40); set_lane(3, 2, 8);
    run_case();   // R7 limit in search for non-zero
    set_lane(0, LIMIT - 1, LIMIT + 5); set_lane(1, LIMIT + 3, LIMIT + 9);
    set_lane(2, 1, 2); set_lane(3, 0, 3);
    run_case();   // R7 limit while leaving the high region
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < LANES; i++) begin
        int h = ($urandom % 2) ? 0 : 1 + $urandom % 6;
        set_lane(i, h, h + 1 + $urandom % (LIMIT - 4));
      end
      run_case(); // R3 random sampling against misleading bus values
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule